// File: doc/BRIEF.md
# Frame Buffer Scanout Read Requester

This block feeds a display pipeline from a two-page frame memory. It walks a raster position over the frame in row-major order. For each position it issues a single-word read on a dedicated read-only AXI4 port. It then converts each returned word into an alpha/red/green/blue pixel and pushes that pixel into the display FIFO.

The scan is paced only by the FIFO. A read is offered only while the FIFO can take data, so the block never holds the memory port busy when the display side is full. The renderer owns a page-select signal and flips it after each frame it finishes. The block registers that select signal and uses it to decide which of the two pages is scanned. Reads are always single-beat, so the block keeps no count of outstanding transactions.

Top module: `fb_scanout_reader`

## Requirements
- R1: Every read request carries length field 0 (one beat), size field 2 (4 bytes) and burst field 2'b00 (fixed).
- R2: `ar_valid` is high exactly in the cycles where `fifo_ready` is high and `rst` is low.
- R3: The raster position advances by one only on a clock edge where `ar_valid` and `ar_ready` are both high; otherwise it holds.
- R4: Column x runs 0..FRAME_W-1. When it wraps to 0, row y increments. Row y wraps from FRAME_H-1 to 0.
- R5: `ar_addr` = page*FRAME_W*FRAME_H*4 + (y*FRAME_W + x)*4, where page is the registered page select.
- R6: The page select is sampled from `page_sel_in` on every clock edge outside reset. It therefore affects `ar_addr` one cycle after it changes.
- R7: Response word bits [7:0] give alpha, [15:8] red, [23:16] green and [31:24] blue.
- R8: `r_ready` follows `fifo_ready`. `pix_push` is high exactly when `r_valid` and `fifo_ready` are both high.
- R9: A synchronous reset returns the position to (0,0), clears the page select to 0 and holds `ar_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| page_sel_in | input | 1 | Page selected for display, driven by the renderer |
| fifo_ready | input | 1 | Display FIFO can accept a pixel |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address accepted by memory |
| ar_addr | output | ADDR_W | Byte address of the pixel word |
| ar_len | output | 8 | Burst length minus one |
| ar_size | output | 3 | log2 of bytes per beat |
| ar_burst | output | 2 | Burst type |
| r_valid | input | 1 | Read data valid |
| r_data | input | 32 | Read data word |
| r_ready | output | 1 | Read data accepted |
| pix_push | output | 1 | Write strobe into the display FIFO |
| pix_a | output | 8 | Alpha channel |
| pix_r | output | 8 | Red channel |
| pix_g | output | 8 | Green channel |
| pix_b | output | 8 | Blue channel |

## Verification
The bench first targets the raster wrap points: the last column of a row and the last pixel of the frame. A counter that wraps one position early or late, or that fails to carry into the row, produces addresses that drift away from the model within one row. Random stalls on either `fifo_ready` or `ar_ready` alone expose a design that advances on a one-sided handshake, because it skips pixels. Page flips at arbitrary cycles catch a select that is used unregistered or is never sampled. Distinct byte patterns in the response word catch swapped channels. A reset in the middle of a frame catches state that survives reset.

// File: rtl/fb_scanout_pkg.sv
package fb_scanout_pkg;
  localparam logic [7:0] SINGLE_BEAT_LEN = 8'd0;
  localparam logic [2:0] WORD_SIZE_CODE  = 3'd2;
  localparam logic [1:0] BURST_FIXED_CODE = 2'b00;

  typedef struct packed {
    logic [7:0] blue;
    logic [7:0] green;
    logic [7:0] red;
    logic [7:0] alpha;
  } argb_t;

  function automatic argb_t word_to_argb(input logic [31:0] w);
    argb_t p;
    p.alpha = w[7:0];
    p.red   = w[15:8];
    p.green = w[23:16];
    p.blue  = w[31:24];
    return p;
  endfunction
endpackage

// File: rtl/fb_raster_counter.sv
module fb_raster_counter #(
  parameter int FRAME_W = 16,
  parameter int FRAME_H = 8,
  localparam int XW = (FRAME_W > 1) ? $clog2(FRAME_W) : 1,
  localparam int YW = (FRAME_H > 1) ? $clog2(FRAME_H) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [XW-1:0] pos_x,
  output logic [YW-1:0] pos_y,
  output logic          row_end,
  output logic          frame_end
);
  localparam logic [XW-1:0] X_LAST = XW'(FRAME_W - 1);
  localparam logic [YW-1:0] Y_LAST = YW'(FRAME_H - 1);

  assign row_end   = (pos_x == X_LAST);
  assign frame_end = row_end && (pos_y == Y_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_x <= '0;
      pos_y <= '0;
    end else if (step) begin
      if (row_end) begin
        pos_x <= '0;
        pos_y <= (pos_y == Y_LAST) ? '0 : pos_y + 1'b1;
      end else begin
        pos_x <= pos_x + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fb_addr_gen.sv
module fb_addr_gen #(
  parameter int FRAME_W = 16,
  parameter int FRAME_H = 8,
  parameter int ADDR_W  = 32,
  localparam int XW = (FRAME_W > 1) ? $clog2(FRAME_W) : 1,
  localparam int YW = (FRAME_H > 1) ? $clog2(FRAME_H) : 1,
  localparam int PAGE_BYTES = FRAME_W * FRAME_H * 4
) (
  input  logic              page,
  input  logic [XW-1:0]     pos_x,
  input  logic [YW-1:0]     pos_y,
  output logic [ADDR_W-1:0] addr
);
  function automatic logic [ADDR_W-1:0] pixel_offset(input logic [XW-1:0] x,
                                                      input logic [YW-1:0] y);
    logic [ADDR_W-1:0] idx;
    idx = ADDR_W'(y) * ADDR_W'(FRAME_W) + ADDR_W'(x);
    return idx << 2;
  endfunction

  function automatic logic [ADDR_W-1:0] page_base(input logic p);
    return p ? ADDR_W'(PAGE_BYTES) : '0;
  endfunction

  assign addr = page_base(page) + pixel_offset(pos_x, pos_y);
endmodule

// File: rtl/fb_scanout_reader.sv
module fb_scanout_reader
  import fb_scanout_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int FRAME_H = 8,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              page_sel_in,
  input  logic              fifo_ready,
  output logic              ar_valid,
  input  logic              ar_ready,
  output logic [ADDR_W-1:0] ar_addr,
  output logic [7:0]        ar_len,
  output logic [2:0]        ar_size,
  output logic [1:0]        ar_burst,
  input  logic              r_valid,
  input  logic [31:0]       r_data,
  output logic              r_ready,
  output logic              pix_push,
  output logic [7:0]        pix_a,
  output logic [7:0]        pix_r,
  output logic [7:0]        pix_g,
  output logic [7:0]        pix_b
);
  localparam int XW = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
  localparam int YW = (FRAME_H > 1) ? $clog2(FRAME_H) : 1;

  logic          page_q;
  logic          req_fire;
  logic [XW-1:0] pos_x;
  logic [YW-1:0] pos_y;
  logic          row_end;
  logic          frame_end;
  argb_t         pix;

  always_ff @(posedge clk) begin
    if (rst) page_q <= 1'b0;
    else     page_q <= page_sel_in;
  end

  assign ar_valid = fifo_ready && !rst;
  assign req_fire = ar_valid && ar_ready;

  fb_raster_counter #(.FRAME_W(FRAME_W), .FRAME_H(FRAME_H)) u_raster (
    .clk(clk), .rst(rst), .step(req_fire),
    .pos_x(pos_x), .pos_y(pos_y), .row_end(row_end), .frame_end(frame_end)
  );

  fb_addr_gen #(.FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .ADDR_W(ADDR_W)) u_addr (
    .page(page_q), .pos_x(pos_x), .pos_y(pos_y), .addr(ar_addr)
  );

  assign ar_len   = SINGLE_BEAT_LEN;
  assign ar_size  = WORD_SIZE_CODE;
  assign ar_burst = BURST_FIXED_CODE;

  assign r_ready  = fifo_ready;
  assign pix_push = r_valid && fifo_ready;
  assign pix      = word_to_argb(r_data);
  assign pix_a    = pix.alpha;
  assign pix_r    = pix.red;
  assign pix_g    = pix.green;
  assign pix_b    = pix.blue;
endmodule

// File: rtl/fb_scanout_sva.sv
module fb_scanout_sva #(
  parameter int FRAME_W = 16,
  parameter int FRAME_H = 8,
  localparam int XW = (FRAME_W > 1) ? $clog2(FRAME_W) : 1,
  localparam int YW = (FRAME_H > 1) ? $clog2(FRAME_H) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          fifo_ready,
  input logic          ar_valid,
  input logic          ar_ready,
  input logic [7:0]    ar_len,
  input logic [2:0]    ar_size,
  input logic [1:0]    ar_burst,
  input logic          r_valid,
  input logic          r_ready,
  input logic          pix_push,
  input logic [XW-1:0] pos_x,
  input logic [YW-1:0] pos_y,
  input logic          row_end,
  input logic          frame_end
);
  a_r1_single_word: assert property (@(posedge clk) disable iff (rst)
    ar_valid |-> (ar_len == 8'd0 && ar_size == 3'd2 && ar_burst == 2'b00));

  a_r2_valid_needs_fifo: assert property (@(posedge clk) disable iff (rst)
    ar_valid |-> fifo_ready);

  a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    !(ar_valid && ar_ready) |=> ($stable(pos_x) && $stable(pos_y)));

  a_r4_row_wrap: assert property (@(posedge clk) disable iff (rst)
    (ar_valid && ar_ready && row_end && !frame_end) |=> (pos_x == '0 && pos_y == $past(pos_y) + 1'b1));

  a_r4_frame_wrap: assert property (@(posedge clk) disable iff (rst)
    (ar_valid && ar_ready && frame_end) |=> (pos_x == '0 && pos_y == '0));

  a_r8_push_handshake: assert property (@(posedge clk) disable iff (rst)
    pix_push |-> (r_valid && r_ready));

  a_r9_reset_origin: assert property (@(posedge clk)
    rst |=> (pos_x == '0 && pos_y == '0));
endmodule

bind fb_scanout_reader fb_scanout_sva #(.FRAME_W(FRAME_W), .FRAME_H(FRAME_H)) u_sva (
  .clk(clk), .rst(rst), .fifo_ready(fifo_ready), .ar_valid(ar_valid),
  .ar_ready(ar_ready), .ar_len(ar_len), .ar_size(ar_size), .ar_burst(ar_burst),
  .r_valid(r_valid), .r_ready(r_ready), .pix_push(pix_push),
  .pos_x(pos_x), .pos_y(pos_y), .row_end(row_end), .frame_end(frame_end)
);

// File: tb/fb_scanout_reader_bench.sv
`timescale 1ns/1ps
module fb_scanout_reader_bench;
  localparam int W = 16;
  localparam int H = 8;
  localparam int AW = 32;

  logic clk = 0;
  logic rst = 1;
  logic page_sel_in = 0, fifo_ready = 0, ar_ready = 0, r_valid = 0;
  logic [31:0] r_data = '0;
  logic ar_valid, r_ready, pix_push;
  logic [AW-1:0] ar_addr;
  logic [7:0] ar_len, pix_a, pix_r, pix_g, pix_b;
  logic [2:0] ar_size;
  logic [1:0] ar_burst;

  int n_checks = 0, n_fail = 0;
  int mx = 0, my = 0, mpage = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fb_scanout_reader #(.FRAME_W(W), .FRAME_H(H), .ADDR_W(AW)) u_fb_scanout_reader (
    .clk(clk), .rst(rst), .page_sel_in(page_sel_in), .fifo_ready(fifo_ready),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_len(ar_len),
    .ar_size(ar_size), .ar_burst(ar_burst), .r_valid(r_valid), .r_data(r_data),
    .r_ready(r_ready), .pix_push(pix_push), .pix_a(pix_a), .pix_r(pix_r),
    .pix_g(pix_g), .pix_b(pix_b)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  // Compare every output against the behavioural model, then advance the model.
  task automatic step_cycle(input bit rs, input bit fr, input bit ard, input bit rv,
                            input bit pg, input logic [31:0] rd);
    @(negedge clk);
    rst = rs; fifo_ready = fr; ar_ready = ard; r_valid = rv; page_sel_in = pg; r_data = rd;
    #2;
    chk("R2 ar_valid", ar_valid, (fr && !rs));
    if (ar_valid) begin
      chk("R1 len", ar_len, 0);
      chk("R1 size", ar_size, 2);
      chk("R1 burst", ar_burst, 0);
    end
    chk("R5/R6 addr", ar_addr, mpage * W * H * 4 + (my * W + mx) * 4);
    chk("R8 r_ready", r_ready, fr);
    chk("R8 push", pix_push, (rv && fr));
    chk("R7 alpha", pix_a, rd[7:0]);
    chk("R7 red", pix_r, rd[15:8]);
    chk("R7 green", pix_g, rd[23:16]);
    chk("R7 blue", pix_b, rd[31:24]);
    @(posedge clk);
    cyc++;
    if (rs) begin
      mx = 0; my = 0; mpage = 0;
    end else begin
      mpage = pg;
      if (fr && ard) begin  // R3 / R4
        mx++;
        if (mx == W) begin
          mx = 0; my++;
          if (my == H) my = 0;
        end
      end
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R9 reset state, with the FIFO ready so ar_valid must still stay low
    repeat (3) step_cycle(1, 1, 1, 0, 1, 32'h0);
    // R3/R4: free running over two whole frames, covering row and frame wraps
    for (int i = 0; i < 2 * W * H + 5; i++)
      step_cycle(0, 1, 1, 1, 0, 32'h11223344 + i);
    // R6: flip the page, its address effect comes one cycle later
    for (int i = 0; i < 10; i++)
      step_cycle(0, 1, 1, 0, (i >= 3), 32'hA0B0C0D0);
    // R2/R3: independent stalls on the FIFO and on the address channel
    for (int i = 0; i < 1200; i++) begin
      logic [31:0] rnd;
      rnd = $urandom;
      step_cycle(0, rnd[0] | rnd[1], rnd[2] | rnd[3], rnd[4], rnd[9] & rnd[10] & rnd[11], $urandom);
    end
    // R9: reset in mid frame
    step_cycle(1, 1, 1, 1, 1, 32'hDEADBEEF);
    // R7: distinct bytes per lane
    step_cycle(0, 1, 0, 1, 0, 32'h04030201);
    step_cycle(0, 1, 1, 1, 0, 32'hFF00FF00);
    // R8: response while the FIFO is full is not pushed
    step_cycle(0, 0, 1, 1, 0, 32'h12345678);
    for (int i = 0; i < 40; i++)
      step_cycle(0, 1, 1, 0, 1, 32'h0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule